// File: doc/BRIEF.md
# Interrupt Priority Resolver with Preemption Decision

This block watches a vector of interrupt request lines, latches each request as pending, and every cycle picks one pending line as the winner. Each line has a programmable priority value. A numerically smaller value is more urgent. When several pending lines share the best value, the lowest-numbered line wins.

Next to the winner, the block decides whether the winner may interrupt what the core is running now. The core gives a context flag, either thread mode or a handler, and the priority of the running handler. In thread mode any winner may enter. While a handler runs, only a winner whose priority value is strictly smaller than the handler's may preempt it. An equal value never preempts, whatever the line index, and that line stays pending.

Priority values are loaded through a single-entry write port. A pending line is cleared only by an acknowledge that names its index. The line count and the priority width are parameters. The winner is found combinationally and registered once.

Top module: `irq_prio_resolver`

## Requirements
- R1: Among pending lines, the one with the numerically smallest priority value is reported on `win_idx`, with its value on `win_prio`.
- R2: When several pending lines share the smallest value, the lowest index wins.
- R3: With `in_handler`=1, `preempt_req` is 1 only if the winner's value is strictly smaller than `run_prio`.
- R4: With `in_handler`=1 and a winner value equal to `run_prio`, `preempt_req` is 0 whatever the index, and the line is still reported as the valid winner.
- R5: With no line pending, `win_valid`, `preempt_req`, `win_idx` and `win_prio` are all 0.
- R6: With `in_handler`=0 (thread mode), any valid winner raises `preempt_req`, even when `run_prio` is 0.
- R7: A line becomes pending when its `irq_in` bit is 1 at a clock edge. It stays pending after the input drops. It is cleared only by `ack_valid`=1 with `ack_idx` equal to that line. An acknowledge of another index has no effect, and a set and an acknowledge of the same line in one cycle leave it pending.
- R8: A write (`cfg_we`=1) stores `cfg_prio` for line `cfg_idx` at the clock edge. Arbitration uses the new value from the next cycle, so the outputs after the write edge still show the old result and the outputs one edge later show the new one.
- R9: A request sampled at edge k appears on the outputs after edge k+1.
- R10: Reset clears all pending bits, all priority values to 0 and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Request lines, sampled each edge |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Line cleared by the acknowledge |
| cfg_we | input | 1 | Priority write enable |
| cfg_idx | input | IDX_W | Line whose priority is written |
| cfg_prio | input | PRIO_W | Priority value written |
| in_handler | input | 1 | 1 = a handler is running, 0 = thread mode |
| run_prio | input | PRIO_W | Priority value of the running handler |
| win_valid | output | 1 | A pending line exists |
| win_idx | output | IDX_W | Index of the winning line |
| win_prio | output | PRIO_W | Priority value of the winner |
| preempt_req | output | 1 | Winner may be entered now |

## Verification
The bench pairs lines that share a value, so a selector that lets the higher index win the tie reports the wrong line. It runs handlers at a value equal to the winner's, where a `<=` comparison would raise a false preempt, and runs thread mode with `run_prio` of 0, where a design that compares even in thread mode would hold back entry. It checks the write port one edge at a time, which catches a design that bypasses the new value into arbitration or delays it by a further cycle. It also checks the pending latch with a same-cycle set and acknowledge and with an acknowledge of another line, which catches an acknowledge that wins over a set or an index decode that clears the wrong bit.

// File: rtl/irqp_pkg.sv
`timescale 1ns/1ps
package irqp_pkg;
  typedef enum logic {
    CTX_THREAD  = 1'b0,
    CTX_HANDLER = 1'b1
  } ctx_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irqp_pending.sv
`timescale 1ns/1ps
module irqp_pending #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] ack_mask;
  logic [NUM_LINES-1:0] pend_d;
  logic [NUM_LINES-1:0] pend_q;

  // one-hot decode of the acknowledge
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ack
    assign ack_mask[i] = ack_valid && (ack_idx == IDX_W'(i));
  end

  // a new request outranks a clearing acknowledge
  always_comb begin
    pend_d = (pend_q & ~ack_mask) | irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqp_prio_bank.sv
`timescale 1ns/1ps
module irqp_prio_bank #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 2,
  parameter int IDX_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [PRIO_W-1:0]           wr_val,
  output logic [NUM_LINES*PRIO_W-1:0] prio_flat
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ent
    logic              ent_en;
    logic [PRIO_W-1:0] ent_q;
    logic [PRIO_W-1:0] ent_d;

    assign ent_en = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      ent_d = ent_q;
      if (ent_en) ent_d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign prio_flat[i*PRIO_W +: PRIO_W] = ent_q;
  end
endmodule

// File: rtl/irqp_select.sv
`timescale 1ns/1ps
module irqp_select #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 2,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_LINES-1:0]        pend,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  output logic                        found,
  output logic [IDX_W-1:0]            best_idx,
  output logic [PRIO_W-1:0]           best_prio
);
  // Ascending scan; a later line replaces the best only when strictly
  // more urgent, so equal values keep the lower index.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend[i]) begin
        if (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
          found     = 1'b1;
          best_idx  = IDX_W'(i);
          best_prio = prio_flat[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
`timescale 1ns/1ps
module irq_prio_resolver #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 2,
  localparam int IDX_W    = irqp_pkg::idx_width(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [PRIO_W-1:0]    cfg_prio,
  input  logic                 in_handler,
  input  logic [PRIO_W-1:0]    run_prio,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_idx,
  output logic [PRIO_W-1:0]    win_prio,
  output logic                 preempt_req
);
  import irqp_pkg::*;

  logic [NUM_LINES-1:0]        pend_q;
  logic [NUM_LINES*PRIO_W-1:0] prio_flat;
  logic                        sel_found;
  logic [IDX_W-1:0]            sel_idx;
  logic [PRIO_W-1:0]           sel_prio;
  ctx_e                        ctx;
  logic                        pre_d;

  irqp_pending #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .pend_o(pend_q)
  );

  irqp_prio_bank #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_val(cfg_prio), .prio_flat(prio_flat)
  );

  irqp_select #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .pend(pend_q), .prio_flat(prio_flat),
    .found(sel_found), .best_idx(sel_idx), .best_prio(sel_prio)
  );

  assign ctx = ctx_e'(in_handler);

  // entry decision: thread mode takes anything, a handler yields only to
  // a strictly smaller value
  always_comb begin
    pre_d = 1'b0;
    if (sel_found) begin
      if (ctx == CTX_THREAD) pre_d = 1'b1;
      else                   pre_d = (sel_prio < run_prio);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid   <= 1'b0;
      win_idx     <= '0;
      win_prio    <= '0;
      preempt_req <= 1'b0;
    end else begin
      win_valid   <= sel_found;
      win_idx     <= sel_idx;
      win_prio    <= sel_prio;
      preempt_req <= pre_d;
    end
  end
endmodule

// File: rtl/irqp_checker.sv
`timescale 1ns/1ps
module irqp_checker #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 2,
  parameter int IDX_W     = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_LINES-1:0]        irq_in,
  input logic                        ack_valid,
  input logic [IDX_W-1:0]            ack_idx,
  input logic                        in_handler,
  input logic [PRIO_W-1:0]           run_prio,
  input logic                        win_valid,
  input logic [IDX_W-1:0]            win_idx,
  input logic [PRIO_W-1:0]           win_prio,
  input logic                        preempt_req,
  input logic [NUM_LINES-1:0]        pend_q,
  input logic [NUM_LINES*PRIO_W-1:0] prio_flat
);
  logic [NUM_LINES-1:0]        pend_prev;
  logic [NUM_LINES*PRIO_W-1:0] prio_prev;
  logic                        better_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_prev <= '0;
      prio_prev <= '0;
    end else begin
      pend_prev <= pend_q;
      prio_prev <= prio_flat;
    end
  end

  always_comb begin
    better_seen = 1'b0;
    for (int j = 0; j < NUM_LINES; j++) begin
      if (pend_prev[j]) begin
        if (prio_prev[j*PRIO_W +: PRIO_W] < win_prio) better_seen = 1'b1;
        if ((IDX_W'(j) < win_idx) && (prio_prev[j*PRIO_W +: PRIO_W] == win_prio))
          better_seen = 1'b1;
      end
    end
  end

  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend_prev[win_idx] && (win_prio == prio_prev[win_idx*PRIO_W +: PRIO_W]))); // R1
  AST_WIN_IS_BEST: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !better_seen); // R2
  AST_NO_PREEMPT_UNLESS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && $past(in_handler) && (win_prio >= $past(run_prio))) |-> !preempt_req); // R4
  AST_HANDLER_LOWER_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && $past(in_handler) && (win_prio < $past(run_prio))) |-> preempt_req); // R3
  AST_THREAD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !$past(in_handler)) |-> preempt_req); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_prev == '0) |-> (!win_valid && !preempt_req)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_valid) && !$past(irq_in[ack_idx])) |-> !pend_q[$past(ack_idx)]); // R7
endmodule

bind irq_prio_resolver irqp_checker #(
  .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
) u_irqp_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_valid(ack_valid),
  .ack_idx(ack_idx), .in_handler(in_handler), .run_prio(run_prio),
  .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio),
  .preempt_req(preempt_req), .pend_q(pend_q), .prio_flat(prio_flat)
);

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;
  localparam int N  = 32;
  localparam int PW = 2;
  localparam int IW = 5;

  typedef struct packed {
    logic [N-1:0]  mask;
    logic          hnd;
    logic [PW-1:0] run;
    logic          ev;
    logic [IW-1:0] ei;
    logic [PW-1:0] ep;
    logic          epre;
  } vec_t;

  // priority map loaded before the table: value = 3 - (index mod 4)
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0021, 1'b0, 2'd0, 1'b1, 5'd5,  2'd2, 1'b1}, // R1 R6
    '{32'h0000_0022, 1'b1, 2'd3, 1'b1, 5'd1,  2'd2, 1'b1}, // R2 R3
    '{32'h0000_0022, 1'b1, 2'd2, 1'b1, 5'd1,  2'd2, 1'b0}, // R4
    '{32'h8000_0001, 1'b1, 2'd1, 1'b1, 5'd31, 2'd0, 1'b1}, // R1 R3
    '{32'h0000_0C00, 1'b1, 2'd0, 1'b1, 5'd11, 2'd0, 1'b0}, // R4
    '{32'h0000_0000, 1'b0, 2'd0, 1'b0, 5'd0,  2'd0, 1'b0}, // R5
    '{32'h0001_0100, 1'b0, 2'd0, 1'b1, 5'd8,  2'd3, 1'b1}, // R2 R6
    '{32'h4400_0000, 1'b1, 2'd3, 1'b1, 5'd26, 2'd1, 1'b1}, // R2 R3
    '{32'h4400_0000, 1'b1, 2'd1, 1'b1, 5'd26, 2'd1, 1'b0}  // R4
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          ack_valid;
  logic [IW-1:0] ack_idx;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [PW-1:0] cfg_prio;
  logic          in_handler;
  logic [PW-1:0] run_prio;
  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic [PW-1:0] win_prio;
  logic          preempt_req;

  int n_chk;
  int n_bad;

  irq_prio_resolver #(.NUM_LINES(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_valid(ack_valid),
    .ack_idx(ack_idx), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
    .in_handler(in_handler), .run_prio(run_prio), .win_valid(win_valid),
    .win_idx(win_idx), .win_prio(win_prio), .preempt_req(preempt_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic ev, input logic [IW-1:0] ei,
                            input logic [PW-1:0] ep, input logic epre);
    n_chk++;
    if (win_valid !== ev || win_idx !== ei || win_prio !== ep || preempt_req !== epre) begin
      n_bad++;
      $display("FAIL %s: got v=%0b idx=%0d prio=%0d pre=%0b, expected v=%0b idx=%0d prio=%0d pre=%0b",
               req, win_valid, win_idx, win_prio, preempt_req, ev, ei, ep, epre);
    end
  endtask

  task automatic ack_all();
    for (int i = 0; i < N; i++) begin
      ack_valid = 1'b1;
      ack_idx   = IW'(i);
      step();
    end
    ack_valid = 1'b0;
    ack_idx   = '0;
  endtask

  task automatic write_prio(input int idx, input logic [PW-1:0] val);
    cfg_we   = 1'b1;
    cfg_idx  = IW'(idx);
    cfg_prio = val;
    step();
    cfg_we   = 1'b0;
  endtask

  task automatic raise(input logic [N-1:0] m);
    irq_in = m;
    step();
    irq_in = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; irq_in = '0; ack_valid = 1'b0; ack_idx = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_prio = '0; in_handler = 1'b0; run_prio = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    expect_out("R10 reset outputs", 1'b0, 5'd0, 2'd0, 1'b0);

    // priorities reset to 0: lines 2 and 4 tie, lower index wins
    raise(32'h0000_0014);
    step();
    expect_out("R10 reset priorities", 1'b1, 5'd2, 2'd0, 1'b1);
    in_handler = 1'b1; run_prio = 2'd0;
    step();
    expect_out("R4 equal to handler", 1'b1, 5'd2, 2'd0, 1'b0);
    in_handler = 1'b0;
    ack_all();

    for (int i = 0; i < N; i++) write_prio(i, PW'(3 - (i % 4)));
    step();

    // table walk
    for (int v = 0; v < NV; v++) begin
      in_handler = VEC[v].hnd;
      run_prio   = VEC[v].run;
      raise(VEC[v].mask);
      step();
      expect_out($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", v),
                 VEC[v].ev, VEC[v].ei, VEC[v].ep, VEC[v].epre);
      ack_all();
      step();
    end
    in_handler = 1'b0; run_prio = '0;

    // R9: latency of a new request
    irq_in = 32'h0000_0008;
    step();
    expect_out("R9 not yet visible", 1'b0, 5'd0, 2'd0, 1'b0);
    irq_in = '0;
    step();
    expect_out("R9 visible after second edge", 1'b1, 5'd3, 2'd0, 1'b1);
    ack_all(); step();

    // R7: sticky pending, foreign ack, set-beats-ack
    raise(32'h0000_0200);
    step(); step(); step();
    expect_out("R7 held after input drop", 1'b1, 5'd9, 2'd2, 1'b1);
    ack_valid = 1'b1; ack_idx = 5'd20;
    step();
    ack_valid = 1'b0;
    step();
    expect_out("R7 other index ack ignored", 1'b1, 5'd9, 2'd2, 1'b1);
    irq_in = 32'h0000_0200; ack_valid = 1'b1; ack_idx = 5'd9;
    step();
    irq_in = '0; ack_valid = 1'b0;
    step();
    expect_out("R7 set wins over ack", 1'b1, 5'd9, 2'd2, 1'b1);
    ack_valid = 1'b1; ack_idx = 5'd9;
    step();
    ack_valid = 1'b0;
    expect_out("R7 ack edge output lags", 1'b1, 5'd9, 2'd2, 1'b1);
    step();
    expect_out("R7 R5 cleared by ack", 1'b0, 5'd0, 2'd0, 1'b0);

    // R8: priority write timing (13 -> 2, 14 -> 1)
    raise(32'h0000_6000);
    step();
    expect_out("R8 before write", 1'b1, 5'd14, 2'd1, 1'b1);
    cfg_we = 1'b1; cfg_idx = 5'd13; cfg_prio = 2'd0;
    step();
    cfg_we = 1'b0;
    expect_out("R8 old value on write edge", 1'b1, 5'd14, 2'd1, 1'b1);
    step();
    expect_out("R8 new value next edge", 1'b1, 5'd13, 2'd0, 1'b1);
    in_handler = 1'b1; run_prio = 2'd1;
    step();
    expect_out("R3 lower than handler", 1'b1, 5'd13, 2'd0, 1'b1);
    in_handler = 1'b0; run_prio = '0;
    write_prio(13, 2'd2);
    ack_all(); step();
    expect_out("R5 idle after clear", 1'b0, 5'd0, 2'd0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule